// File: doc/BRIEF.md
# Word-Serial Dual-Field Add/Subtract-and-Halve Unit

This unit combines two multi-word operands, x and y, one W-bit word per clock, least significant word first. It can form (x−y)/2, (x+y)/2, x−y or x+y. In integer mode, a single carry bit carries the carry or borrow from one word to the next. In binary-polynomial mode, words are combined by XOR and no carry passes between them. The halving shift is folded into the stream. The top bit of each output word is bit 0 of the next word's raw result, so every output word leaves one cycle after its raw word is formed.

While the words pass through, the unit tracks how long the result is in bits. That length is built up in a scratch register and copied to the visible length output only after the last word. Until then, a sequencer that polls the length still sees the previous result's value. The unit also reports the sign of an integer subtraction and a zero flag. The zero flag tells an inversion loop when to stop. The operand words come from an external register file, and that register file takes the written-back words in order.

The controller has four named states:
- IDLE waits for `start`.
- RUN takes words 1 to WORDS−1.
- FLUSH emits the last output word, with no input word that cycle.
- DONE marks the cycle in which the result and the flags are complete.

Its transitions are:
- IDLE→RUN when `start` is high.
- RUN→FLUSH on the last word.
- FLUSH→DONE and DONE→IDLE unconditionally.

Top module: `serial_dual_addhalf`

## Requirements
- R1: In integer mode, `op_sel` 2'b00 yields (x−y)/2 and 2'b01 yields (x+y)/2. Both are formed from the exact (WORDS·W+1)-bit result and shifted right by one. The top bit of the last word is the carry out for the add, or the sign (borrow) for the subtract.
- R2: In integer mode, `op_sel` 2'b10 yields x−y and 2'b11 yields x+y, modulo 2^(WORDS·W). A carry or borrow links adjacent words.
- R3: When `gf2_mode`=1, words combine by bitwise XOR with no carry between words. The halved variants (op 2'b00/2'b01) shift the XOR right by one with a 0 in the top bit.
- R4: Word j of x and y is presented in the cycle `start` is taken plus j. Output word j appears with `out_we`=1 and `out_idx`=j two cycles after that start cycle plus j. The output words come in ascending order with no gaps.
- R5: `done` is high for exactly one cycle, WORDS+1 cycles after the start cycle, together with the last output word. `busy` is high from the cycle after start through that cycle. A new start is accepted from the following cycle on.
- R6: `start` has no effect while `busy` is high, including in the DONE cycle.
- R7: `res_len` is the index of the highest set bit of the written result, plus one, or 0 if the result is zero. It changes only in the DONE cycle and holds the previous result's value until then.
- R8: `res_zero` is 1 exactly when `res_len` is 0, and it is updated together with `res_len`.
- R9: `res_neg` is 1 when an integer subtraction (op 2'b00 or 2'b10) has x<y. It is 0 for additions and in binary-polynomial mode.
- R10: After reset the unit is idle with `busy`, `done`, `out_we`, `res_neg` and `res_len` at 0 and `res_zero` at 1.
- R11: Opcode and mode are captured in the start cycle. Changes to `op_sel` and `gf2_mode` during the operation have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; word 0 is on the inputs in this cycle |
| op_sel | input | 2 | 00 sub-halve, 01 add-halve, 10 sub, 11 add |
| gf2_mode | input | 1 | 1 = carry-free XOR combination |
| x_word | input | W | Current word of x |
| y_word | input | W | Current word of y |
| out_we | output | 1 | Write enable for the result word |
| out_idx | output | $clog2(WORDS) | Index of the result word |
| out_word | output | W | Result word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result and flags complete this cycle |
| res_neg | output | 1 | Integer subtraction result negative |
| res_len | output | $clog2(WORDS·W+1) | Committed bit length of the result |
| res_zero | output | 1 | Committed bit length is zero |

## Verification
The assertions assume that `start` is sampled only when it is meant, and that `rst_n` is held for at least one clock edge. They also assume that the caller presents exactly WORDS consecutive input words and never stalls the stream. The property that a new `res_len` appears only with `done` holds only because no input can hold the unit mid-stream. The stimulus drives every word on the falling edge, in back-to-back cycles. It raises `start` in mid-stream or in the DONE cycle only as a deliberate probe, and it scrambles the opcode and mode during a run only to show that they are ignored.

// File: rtl/sdah_pkg.sv
package sdah_pkg;

    typedef enum logic [1:0] {
        OP_SUB_HALF = 2'b00,
        OP_ADD_HALF = 2'b01,
        OP_SUB      = 2'b10,
        OP_ADD      = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

endpackage

// File: rtl/sdah_word_alu.sv
module sdah_word_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         gf,
    output logic [W-1:0] d,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        if (gf) begin
            d    = a ^ b;
            cout = 1'b0;
        end else begin
            d    = sum[W-1:0];
            cout = sum[W];
        end
    end
endmodule

// File: rtl/sdah_msb.sv
module sdah_msb #(
    parameter int W  = 32,
    localparam int LWW = $clog2(W + 1)
) (
    input  logic [W-1:0]   v,
    output logic [LWW-1:0] len
);
    always_comb begin
        len = '0;
        for (int i = 0; i < W; i++) begin
            if (v[i]) len = LWW'(i + 1);
        end
    end
endmodule

// File: rtl/serial_dual_addhalf.sv
module serial_dual_addhalf
    import sdah_pkg::*;
#(
    parameter int W     = 32,
    parameter int WORDS = 5,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int TOT  = W * WORDS,
    localparam int LW   = $clog2(TOT + 1),
    localparam int LWW  = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_sel,
    input  logic          gf2_mode,
    input  logic [W-1:0]  x_word,
    input  logic [W-1:0]  y_word,
    output logic          out_we,
    output logic [IW-1:0] out_idx,
    output logic [W-1:0]  out_word,
    output logic          busy,
    output logic          done,
    output logic          res_neg,
    output logic [LW-1:0] res_len,
    output logic          res_zero
);
    st_e           st_q, st_d;
    logic [1:0]    op_q;
    logic          gf_q;
    logic          carry_q;
    logic [W-1:0]  prev_q;
    logic [IW-1:0] cnt_q;
    logic [LW-1:0] tmp_len_q;

    logic          first;
    logic [1:0]    cur_op;
    logic          cur_gf;
    logic          cur_sub;
    logic          alu_cin;
    logic [W-1:0]  diff;
    logic          alu_cout;
    logic          halve_q;
    logic          top_bit;
    logic          shift_in;
    logic [W-1:0]  emit_word;
    logic [IW-1:0] emit_idx;
    logic [LWW-1:0] word_len;
    logic [LW-1:0] new_len;

    // operation select: live in the start cycle, latched afterwards
    assign first   = (st_q == ST_IDLE) && start;
    assign cur_op  = first ? op_sel : op_q;
    assign cur_gf  = first ? gf2_mode : gf_q;
    assign cur_sub = (cur_op == OP_SUB_HALF) || (cur_op == OP_SUB);
    assign alu_cin = first ? cur_sub : carry_q;

    sdah_word_alu #(.W(W)) u_alu (
        .a    (x_word),
        .b    (y_word),
        .cin  (alu_cin),
        .sub  (cur_sub),
        .gf   (cur_gf),
        .d    (diff),
        .cout (alu_cout)
    );

    // skewed halving: bit 0 of the current raw word tops the previous one
    assign halve_q  = (op_q == OP_SUB_HALF) || (op_q == OP_ADD_HALF);
    assign top_bit  = gf_q ? 1'b0 : ((op_q == OP_ADD_HALF) ? carry_q : ~carry_q);
    assign shift_in = (st_q == ST_FLUSH) ? top_bit : diff[0];
    assign emit_word = halve_q ? {shift_in, prev_q[W-1:1]} : prev_q;
    assign emit_idx  = (st_q == ST_FLUSH) ? IW'(WORDS - 1) : (cnt_q - 1'b1);

    sdah_msb #(.W(W)) u_msb (
        .v   (emit_word),
        .len (word_len)
    );

    assign new_len = (word_len != '0)
                   ? (LW'(emit_idx) * LW'(W) + LW'(word_len))
                   : tmp_len_q;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_RUN;
            ST_RUN:   if (cnt_q == IW'(WORDS - 1)) st_d = ST_FLUSH;
            ST_FLUSH: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign busy = (st_q != ST_IDLE);
    assign done = (st_q == ST_DONE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            gf_q      <= 1'b0;
            carry_q   <= 1'b0;
            prev_q    <= '0;
            cnt_q     <= '0;
            tmp_len_q <= '0;
            out_we    <= 1'b0;
            out_idx   <= '0;
            out_word  <= '0;
            res_neg   <= 1'b0;
            res_len   <= '0;
            res_zero  <= 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    out_we <= 1'b0;
                    if (start) begin
                        op_q      <= op_sel;
                        gf_q      <= gf2_mode;
                        prev_q    <= diff;
                        carry_q   <= alu_cout;
                        cnt_q     <= IW'(1);
                        tmp_len_q <= '0;
                    end
                end
                ST_RUN: begin
                    out_we    <= 1'b1;
                    out_idx   <= emit_idx;
                    out_word  <= emit_word;
                    tmp_len_q <= new_len;
                    prev_q    <= diff;
                    carry_q   <= alu_cout;
                    cnt_q     <= cnt_q + 1'b1;
                end
                ST_FLUSH: begin
                    out_we   <= 1'b1;
                    out_idx  <= emit_idx;
                    out_word <= emit_word;
                    res_len  <= new_len;
                    res_zero <= (new_len == '0);
                    res_neg  <= !gf_q && (op_q == OP_SUB_HALF || op_q == OP_SUB) && !carry_q;
                end
                ST_DONE: begin
                    out_we <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sdah_chk.sv
module sdah_chk #(
    parameter int W     = 32,
    parameter int WORDS = 5,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LW   = $clog2(W * WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          out_we,
    input logic [IW-1:0] out_idx,
    input logic [LW-1:0] res_len,
    input logic          res_zero
);
    // R5
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> busy);

    // R4
    last_word_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_idx == IW'(WORDS - 1)) |-> done);

    // R4
    idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && $past(out_we)) |-> (out_idx == IW'($past(out_idx) + 1'b1)));

    // R7
    len_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_len) |-> done);

    // R8
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_zero == (res_len == '0));

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind serial_dual_addhalf sdah_chk #(.W(W), .WORDS(WORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .out_we   (out_we),
    .out_idx  (out_idx),
    .res_len  (res_len),
    .res_zero (res_zero)
);

// File: tb/sim_serial_dual_addhalf.sv
`timescale 1ns/1ps
module sim_serial_dual_addhalf;
    localparam int W     = 32;
    localparam int WORDS = 5;
    localparam int IW    = $clog2(WORDS);
    localparam int TOT   = W * WORDS;
    localparam int LW    = $clog2(TOT + 1);
    localparam int NV    = 10;

    localparam logic [TOT-1:0] VX [NV] = '{
        160'd1000, 160'd5, {TOT{1'b1}}, 160'h1_0000_0000_0000_0000, 160'hFFFF_FFFF,
        160'hF0, {TOT{1'b1}}, 160'h1234_5678_9abc_def0_1111_2222_3333_4444_5555_6666,
        160'h1_0000_0000, 160'd3 };
    localparam logic [TOT-1:0] VY [NV] = '{
        160'd1, 160'd9, {TOT{1'b1}}, 160'd1, 160'd1,
        160'h0F, 160'd1, 160'h1234_5678_9abc_def0_1111_2222_3333_4444_5555_6666,
        160'd0, 160'd7 };
    localparam logic [1:0] VOP [NV] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b11,
                                        2'b00, 2'b11, 2'b00, 2'b00, 2'b10};
    localparam bit VGF [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_sel = '0;
    logic          gf2_mode = 1'b0;
    logic [W-1:0]  x_word = '0;
    logic [W-1:0]  y_word = '0;
    logic          out_we;
    logic [IW-1:0] out_idx;
    logic [W-1:0]  out_word;
    logic          busy, done, res_neg, res_zero;
    logic [LW-1:0] res_len;

    int nchk = 0;
    int nerr = 0;
    logic [LW-1:0] prev_len = '0;

    always #2 clk = ~clk;

    serial_dual_addhalf #(.W(W), .WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .gf2_mode(gf2_mode), .x_word(x_word), .y_word(y_word),
        .out_we(out_we), .out_idx(out_idx), .out_word(out_word),
        .busy(busy), .done(done), .res_neg(res_neg),
        .res_len(res_len), .res_zero(res_zero)
    );

    task automatic chk(input bit ok, input string rq, input logic [TOT:0] act, input logic [TOT:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_op(input logic [TOT-1:0] x, input logic [TOT-1:0] y,
                          input logic [1:0] op, input bit gf,
                          input bit scramble, input bit mid_start, input string tag);
        logic [TOT:0]   full;
        logic [TOT-1:0] exp_res;
        logic [TOT-1:0] got;
        logic [LW-1:0]  exp_len;
        bit             exp_neg;
        bit             timing_ok;
        int             ncap;
        bit             halve;
        string          rq;
        halve = !op[1];
        if (gf) full = {1'b0, x ^ y};
        else if (!op[0]) full = {1'b0, x} - {1'b0, y};
        else full = {1'b0, x} + {1'b0, y};
        exp_res = halve ? full[TOT:1] : full[TOT-1:0];
        exp_neg = !gf && !op[0] && full[TOT];
        exp_len = '0;
        for (int i = 0; i < TOT; i++) if (exp_res[i]) exp_len = LW'(i + 1);
        got = '0; ncap = 0; timing_ok = 1'b1;

        @(negedge clk);
        start = 1'b1; op_sel = op; gf2_mode = gf;
        x_word = x[0 +: W]; y_word = y[0 +: W];
        for (int k = 1; k <= WORDS + 1; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                if (!(out_we && out_idx == IW'(k - 2))) timing_ok = 1'b0;
            end else if (out_we) timing_ok = 1'b0;
            if (out_we) begin
                got[out_idx * W +: W] = out_word;
                ncap++;
            end
            start = mid_start && (k == 2);
            if (scramble) begin op_sel = ~op; gf2_mode = ~gf; end
            if (k < WORDS) begin
                x_word = x[k * W +: W]; y_word = y[k * W +: W];
            end else begin
                x_word = '0; y_word = '0;
            end
            if (k == WORDS) begin
                // R7 old length visible while the last word is in flight
                chk(res_len == prev_len && !done, {tag, " R7 hold"}, TOT'(res_len), TOT'(prev_len));
            end
        end
        // R5 done exactly WORDS+1 cycles after start
        chk(done && busy, {tag, " R5 done"}, {done, busy}, 2'b11);
        // R4 word order and count
        chk(timing_ok && ncap == WORDS, {tag, " R4 stream"}, ncap, WORDS);
        rq = gf ? "R3" : (op[1] ? "R2" : "R1");
        chk(got == exp_res, {tag, " ", rq, " result"}, got, exp_res);
        // R7 / R8 / R9 flags
        chk(res_len == exp_len, {tag, " R7 length"}, TOT'(res_len), TOT'(exp_len));
        chk(res_zero == (exp_len == 0), {tag, " R8 zero"}, res_zero, exp_len == 0);
        chk(res_neg == exp_neg, {tag, " R9 sign"}, res_neg, exp_neg);
        prev_len = exp_len;
        op_sel = '0; gf2_mode = 1'b0;
    endtask

    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !out_we, "R10 idle", {busy, done, out_we}, 3'b000);
        chk(res_len == '0 && res_zero && !res_neg, "R10 flags",
            {res_len, res_zero, res_neg}, {LW'(0), 1'b1, 1'b0});

        for (int v = 0; v < NV; v++) begin
            run_op(VX[v], VY[v], VOP[v], VGF[v], 1'b0, 1'b0, "vec");
        end

        // R6: start during DONE ignored, unit returns to IDLE
        run_op(160'd77, 160'd12, 2'b10, 1'b0, 1'b0, 1'b0, "pre");
        start = 1'b1; x_word = '1; y_word = '1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R6 start in done", busy, 1'b0);
        @(negedge clk);
        chk(!busy && res_len == prev_len, "R6 stays idle", TOT'(res_len), TOT'(prev_len));

        // R6: start in mid-stream ignored
        run_op(160'hABCD_0000_1234_5678_0000_0001, 160'h0000_0001_0000_0000_0000_0003,
               2'b00, 1'b0, 1'b0, 1'b1, "R6 midstart");

        // R11: opcode and mode changes after start ignored
        run_op(160'h8000_0000_0000_0000_0000_0000_0000_0000_0000_0003, 160'd9,
               2'b01, 1'b0, 1'b1, 1'b0, "R11 scramble");
        run_op(160'h55AA, 160'hFF00, 2'b10, 1'b1, 1'b1, 1'b0, "R11 gf scramble");

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule